// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer with Interrupt Gating

This block is an 8-bit up-counter that advances only in cycles where a tick strobe from an external timebase is high. Two 8-bit compare registers, channel A and channel B, are checked against the count on each tick. The result sets a sticky flag and toggles a registered output pin for that channel. When the count wraps, a third sticky flag records the overflow. Software reaches the counter, both compare values, a three-bit enable mask and the flags through a simple synchronous register bus. Software clears a flag by writing a one to it.

Each of the three interrupt requests is the AND of its flag, its mask bit and a global enable input. When software loads the counter, the next tick cannot produce a compare match on either channel. This stops a freshly written value from firing a spurious event.

The reset input is asserted asynchronously and released through a two-stage synchronizer. Bus reads are combinational from the address. Bus writes take effect at the clock edge.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the following read as zero: counter, compare A, compare B, mask and flags. Both wave outputs and all interrupt requests are low.
- R2: The counter increments by one at each clock edge where `tick_en` is high and no counter write occurs, wrapping from 255 to 0. It holds when `tick_en` is low.
- R3: A tick that takes the count from 255 to 0 sets flag bit 0, the overflow flag.
- R4: A tick in a cycle where the present count equals compare A sets flag bit 1. The same rule with compare B sets flag bit 2.
- R5: A bus write to the counter loads the written value. If the write coincides with a tick, the counter does not increment. The tick that follows a counter write produces no compare match on either channel.
- R6: Writing a 1 to a flag bit at address 4 clears that flag, and writing a 0 leaves it unchanged. A set event in the same cycle as a clear write leaves the flag set.
- R7: The mask register at address 3 stores only bits 2:0, with bit 0 for overflow, bit 1 for compare A and bit 2 for compare B. Bits 7:3 read as zero whatever was written.
- R8: `irq_req[i]` is high exactly when flag bit i, mask bit i and `gie` are all high.
- R9: Each compare match that is not blocked toggles that channel's wave output (`cmp_wave[0]` for A, `cmp_wave[1]` for B).
- R10: The register map is: counter at address 0, compare A at 1, compare B at 2, mask at 3, flags at 4. Addresses 5 to 7 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick strobe; the count advances when high |
| gie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_req | output | 3 | Interrupt requests: bit 0 overflow, bit 1 compare A, bit 2 compare B |
| cmp_wave | output | 2 | Toggle outputs: bit 0 channel A, bit 1 channel B |

## Verification
The checker enforces the following on every cycle:
- The counter holds, increments or loads according to the tick and the write strobe.
- A counter write leaves both wave outputs unchanged at that edge.
- A wave output only changes together with its channel flag.
- Interrupts stay low while `gie` is low.
- The reserved mask bits read as zero.

Some behaviours need stimulus sequences, so only the bench scenarios can show them:
- The tick after a counter write is suppressed while later ticks still match.
- A set event wins over a same-cycle clear.
- The 255-to-0 wrap raises overflow.
- The per-source masking of interrupts works.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    ADDR_CNT  = 3'd0,
    ADDR_CMPA = 3'd1,
    ADDR_CMPB = 3'd2,
    ADDR_MASK = 3'd3,
    ADDR_FLAG = 3'd4
  } tmr_addr_e;

  localparam int unsigned SRC_OVF  = 0;
  localparam int unsigned SRC_CMPA = 1;
  localparam int unsigned SRC_CMPB = 2;
  localparam int unsigned NSRC     = 3;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         tick_eff,
  output logic         wrap,
  output logic         blk
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_n;
  logic         blk_q, blk_n;
  logic         cnt_en;

  assign tick_eff = tick & ~wr;
  assign wrap     = tick_eff & (cnt_q == CNT_MAX);
  assign cnt_en   = wr | tick;

  always_comb begin
    cnt_n = cnt_q;
    blk_n = blk_q;
    if (wr) begin
      cnt_n = wdata;
      blk_n = 1'b1;
    end else if (tick) begin
      cnt_n = cnt_q + {{(W-1){1'b0}}, 1'b1};
      blk_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
      blk_q <= blk_n;
    end
  end

  assign cnt = cnt_q;
  assign blk = blk_q;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ocr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  input  logic         tick_eff,
  input  logic         blk,
  output logic [W-1:0] ocr,
  output logic         match,
  output logic         wave
);
  logic [W-1:0] ocr_q;
  logic         wave_q, wave_n;

  assign match  = tick_eff & ~blk & (cnt == ocr_q);
  assign wave_n = wave_q ^ match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_q <= '0;
    end else if (wr_ocr) begin
      ocr_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
    end else if (match) begin
      wave_q <= wave_n;
    end
  end

  assign ocr  = ocr_q;
  assign wave = wave_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         wr_flag,
  input  logic         wr_mask,
  input  logic [N-1:0] wdata,
  input  logic         gie,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  logic [N-1:0] flag_q, flag_n, clr;
  logic [N-1:0] mask_q;

  assign clr    = wr_flag ? wdata : '0;
  assign flag_n = set_ev | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= wdata;
    end
  end

  assign flags = flag_q;
  assign mask  = mask_q;
  assign irq   = flag_q & mask_q & {N{gie}};
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gie,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [2:0]    irq_req,
  output logic [1:0]    cmp_wave
);
  import tmr_pkg::*;

  localparam int unsigned NCH = 2;

  logic [1:0]      rst_sync_q;
  logic            rst_s;
  logic            cnt_wr, flag_wr, mask_wr;
  logic [W-1:0]    cnt_q;
  logic            tick_eff, wrap, blk;
  logic [NCH-1:0]  match;
  logic [W-1:0]    ocr [NCH];
  logic [NSRC-1:0] flags, mask, set_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s = rst_sync_q[1];

  assign cnt_wr  = bus_we & (bus_addr == AW'(ADDR_CNT));
  assign mask_wr = bus_we & (bus_addr == AW'(ADDR_MASK));
  assign flag_wr = bus_we & (bus_addr == AW'(ADDR_FLAG));

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .tick(tick_en), .wr(cnt_wr), .wdata(bus_wdata),
    .cnt(cnt_q), .tick_eff(tick_eff), .wrap(wrap), .blk(blk)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_ocr;
    assign wr_ocr = bus_we & (bus_addr == AW'(int'(ADDR_CMPA) + g));
    tmr_compare #(.W(W)) u_cmp (
      .clk(clk), .rst_n(rst_s), .wr_ocr(wr_ocr), .wdata(bus_wdata),
      .cnt(cnt_q), .tick_eff(tick_eff), .blk(blk),
      .ocr(ocr[g]), .match(match[g]), .wave(cmp_wave[g])
    );
  end

  assign set_ev[SRC_OVF]  = wrap;
  assign set_ev[SRC_CMPA] = match[0];
  assign set_ev[SRC_CMPB] = match[1];

  tmr_irq #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_s), .set_ev(set_ev), .wr_flag(flag_wr),
    .wr_mask(mask_wr), .wdata(bus_wdata[NSRC-1:0]), .gie(gie),
    .flags(flags), .mask(mask), .irq(irq_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(ADDR_CNT):  bus_rdata = cnt_q;
      AW'(ADDR_CMPA): bus_rdata = ocr[0];
      AW'(ADDR_CMPB): bus_rdata = ocr[1];
      AW'(ADDR_MASK): bus_rdata = {{(W-NSRC){1'b0}}, mask};
      AW'(ADDR_FLAG): bus_rdata = {{(W-NSRC){1'b0}}, flags};
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cnt_wr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  cnt,
  input logic          gie,
  input logic [2:0]    irq,
  input logic [1:0]    wave,
  input logic [2:0]    flags,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  rdata
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (cnt == W'($past(cnt) + 1'b1)));
  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata)));
  // R5
  wr_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> $stable(wave));
  // R9
  wave_a_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave[0]) |-> flags[1]);
  // R9
  wave_b_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave[1]) |-> flags[2]);
  // R8
  irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == 3'b000));
  // R7
  mask_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(3)) |-> (rdata[W-1:3] == '0));
endmodule

bind dual_cmp_timer tmr_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_s), .tick(tick_en), .cnt_wr(cnt_wr), .wdata(bus_wdata),
  .cnt(cnt_q), .gie(gie), .irq(irq_req), .wave(cmp_wave), .flags(flags),
  .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, gie, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [2:0] irq_req;
  logic [1:0] cmp_wave;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_cmp_timer i_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gie(gie), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .cmp_wave(cmp_wave)
  );

  // vector: kind[16:15] (0 write, 1 read-check, 2 ticks), addr[14:12], data[11:4], req[3:0]
  localparam int NV = 22;
  localparam logic [16:0] VEC [NV] = '{
    {2'd1, 3'd0, 8'h00, 4'd1},   // R1 counter zero
    {2'd1, 3'd4, 8'h00, 4'd1},   // R1 flags zero
    {2'd0, 3'd1, 8'h05, 4'd10},  // R10 write compare A
    {2'd0, 3'd2, 8'h09, 4'd10},  // R10 write compare B
    {2'd1, 3'd1, 8'h05, 4'd10},  // R10 read compare A
    {2'd1, 3'd2, 8'h09, 4'd10},  // R10 read compare B
    {2'd2, 3'd0, 8'd3,  4'd2},   // R2 three ticks
    {2'd1, 3'd0, 8'h03, 4'd2},   // R2 count 3
    {2'd2, 3'd0, 8'd3,  4'd4},   // R4 ticks at 3,4,5
    {2'd1, 3'd4, 8'h02, 4'd4},   // R4 flag A
    {2'd0, 3'd4, 8'h02, 4'd6},   // R6 clear A
    {2'd1, 3'd4, 8'h00, 4'd6},   // R6 cleared
    {2'd0, 3'd3, 8'hFF, 4'd7},   // R7 mask all ones
    {2'd1, 3'd3, 8'h07, 4'd7},   // R7 reserved zero
    {2'd0, 3'd0, 8'h09, 4'd5},   // R5 load counter = compare B
    {2'd2, 3'd0, 8'd1,  4'd5},   // R5 blocked tick
    {2'd1, 3'd4, 8'h00, 4'd5},   // R5 no flag B
    {2'd1, 3'd0, 8'h0A, 4'd5},   // R5 counter advanced
    {2'd0, 3'd0, 8'hFE, 4'd3},   // R3 load near top
    {2'd2, 3'd0, 8'd2,  4'd3},   // R3 wrap
    {2'd1, 3'd4, 8'h01, 4'd3},   // R3 overflow flag
    {2'd1, 3'd6, 8'h00, 4'd10}   // R10 unmapped read
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [1:0] w0;
    tick_en = 0; gie = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][16:15])
        2'd0: wr(VEC[i][14:12], VEC[i][11:4]);
        2'd1: begin
          rd(VEC[i][14:12], d);
          check($sformatf("R%0d vec %0d", VEC[i][3:0], i), d, VEC[i][11:4]);
        end
        default: ticks(int'(VEC[i][11:4]));
      endcase
    end

    // R9: unblocked match on A toggles cmp_wave[0]; flags cleared first
    wr(3'd4, 8'h07);
    wr(3'd1, 8'h14);
    wr(3'd0, 8'h13);
    ticks(1);              // blocked tick at 0x13, count 0x14
    @(negedge clk); w0 = cmp_wave;
    ticks(1);              // match at 0x14
    @(negedge clk);
    check("R9 wave A toggled", {6'd0, cmp_wave}, {6'd0, w0 ^ 2'b01});

    // R8: flag A set, mask 7
    gie = 1'b0; #1;
    check("R8 gie low", {5'd0, irq_req}, 8'h00);
    gie = 1'b1; #1;
    check("R8 flag A irq", {5'd0, irq_req}, 8'h02);
    wr(3'd3, 8'h05);
    #1 check("R8 masked A", {5'd0, irq_req}, 8'h00);

    // R6: set wins over same-cycle clear
    wr(3'd4, 8'h07);
    wr(3'd0, 8'h13);
    ticks(1);              // blocked, count 0x14
    @(negedge clk);
    tick_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h07;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    rd(3'd4, d);
    check("R6 set wins", d, 8'h02);
    wr(3'd4, 8'h00);
    rd(3'd4, d);
    check("R6 write zero keeps", d, 8'h02);

    // R5: write coinciding with tick loads without increment
    @(negedge clk);
    tick_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h32;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    rd(3'd0, d);
    check("R5 load with tick", d, 8'h32);

    // R2: no tick, no change
    repeat (5) @(negedge clk);
    rd(3'd0, d);
    check("R2 hold", d, 8'h32);

    // R10: write to unmapped address leaves registers alone
    wr(3'd5, 8'hAA);
    rd(3'd1, d);
    check("R10 unmapped write", d, 8'h14);

    // R1: reset clears everything
    do_reset();
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 addr %0d", a), d, 8'h00);
    end
    check("R1 wave", {6'd0, cmp_wave}, 8'h00);
    check("R1 irq", {5'd0, irq_req}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule